// File: doc/BRIEF.md
# Sprite Memory Access Gate

This block sits between a processor bus and a 160-byte sprite attribute store. The store is mapped at a fixed window. For each processor access the block decides whether it reaches the store. Two inputs drive that decision: the display controller's current mode and a flag that says a bulk copy engine is running. An access that is refused does not stall the bus. A refused read returns 0xFF and a refused write is dropped.

The copy engine has its own write port into the store. That port is honoured on every cycle the engine is running, whatever the display mode. Read data is registered and appears one cycle after the request, whether it comes from the store or is the 0xFF substitute.

Top module: `sprite_mem_gate`

## Requirements
- R1: After reset `rd_data` is 0xFF. The store contents are undefined until written.
- R2: The window covers bus addresses 0xFE00 to 0xFE9F, which is 160 bytes. Byte index = address − 0xFE00.
- R3: The display mode input `lcd_mode` is encoded as 0 = horizontal blank, 1 = vertical blank, 2 = sprite scan, 3 = drawing.
- R4: When `copy_busy` is low and `lcd_mode` is 0 or 1, a processor write in the window stores `wr_data` at its byte index.
- R5: When `copy_busy` is low and `lcd_mode` is 0 or 1, a processor read in the window returns the stored byte on `rd_data` in the next cycle.
- R6: When `copy_busy` is low and `lcd_mode` is 2 or 3, a processor read in the window returns 0xFF in the next cycle and a processor write is dropped.
- R7: When `copy_busy` is high, a processor read in the window returns 0xFF in the next cycle and a processor write is dropped, whatever the mode.
- R8: While `copy_busy` is high, a copy-port write (`cp_we`, `cp_idx`, `cp_data`) stores its byte in any mode. The copy port has no effect while `copy_busy` is low.
- R9: Addresses 0xFEA0 to 0xFEFF, and every other address outside the window, never touch the store. A read there returns 0xFF in the next cycle.
- R10: The gating decision uses the `lcd_mode` and `copy_busy` values present in the same cycle as the request.
- R11: When there is no read request, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcd_mode | input | 2 | Display mode (R3 encoding) |
| copy_busy | input | 1 | Bulk copy engine running |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Processor read request |
| bus_wr | input | 1 | Processor write request |
| wr_data | input | 8 | Processor write byte |
| rd_data | output | 8 | Registered read byte |
| cp_we | input | 1 | Copy engine write strobe |
| cp_idx | input | 8 | Copy engine byte index (0 to 159) |
| cp_data | input | 8 | Copy engine write byte |

## Verification
The bench sends random mixes of mode, busy flag, address and direction. It compares every read against a model store that it updates only when the requirements allow a write. This separates correct gating from gating that is wrong in a single mode or for a busy flag taken from the wrong cycle. Directed cases cover the following:
- the window edges 0xFE00 and 0xFE9F;
- the first prohibited address 0xFEA0;
- a write made during drawing, followed by a read in blanking, which shows the dropped write did not land;
- copy-port writes made while the engine is idle, which must leave the store unchanged.

// File: rtl/sprite_mem_gate.sv
module sprite_mem_gate #(
  parameter int unsigned BASE  = 16'hFE00,
  parameter int unsigned DEPTH = 160,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lcd_mode,
  input  logic          copy_busy,
  input  logic [15:0]   bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cp_we,
  input  logic [7:0]    cp_idx,
  input  logic [DW-1:0] cp_data
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [15:0]   off;
  logic          in_win, open, cpu_ok, cp_ok;
  logic [IW-1:0] cpu_i, cp_i;

  assign off    = bus_addr - 16'(BASE);
  assign in_win = bus_addr >= 16'(BASE) && off < 16'(DEPTH);
  assign open   = !copy_busy && (lcd_mode == 2'd0 || lcd_mode == 2'd1);
  assign cpu_ok = in_win && open;
  assign cpu_i  = off[IW-1:0];
  assign cp_ok  = copy_busy && cp_we && cp_idx < 8'(DEPTH);
  assign cp_i   = cp_idx[IW-1:0];

  always_ff @(posedge clk) begin
    if (cp_ok)
      mem[cp_i] <= cp_data;
    else if (bus_wr && cpu_ok)
      mem[cpu_i] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '1;
    else if (bus_rd)
      rd_data <= cpu_ok ? mem[cpu_i] : '1;
  end

  a_r7_busy_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && copy_busy) |=> rd_data == '1);
  a_r6_scan_draw_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && lcd_mode[1]) |=> rd_data == '1);
  a_r9_outside_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr < 16'(BASE) || bus_addr >= 16'(BASE + DEPTH))) |=> rd_data == '1);
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rd_data));
  a_r1_reset_value: assert property (@(posedge clk)
    !rst_n |=> rd_data == '1);
endmodule

// File: tb/sprite_mem_gate_bench.sv
module sprite_mem_gate_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] lcd_mode = 0;
  logic copy_busy = 0, bus_rd = 0, bus_wr = 0, cp_we = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] wr_data = 0, cp_idx = 0, cp_data = 0;
  logic [7:0] rd_data;
  logic [7:0] model [160];
  bit known [160];
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  sprite_mem_gate u_sprite_mem_gate (.clk, .rst_n, .lcd_mode, .copy_busy,
    .bus_addr, .bus_rd, .bus_wr, .wr_data, .rd_data, .cp_we, .cp_idx, .cp_data);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit in_win(logic [15:0] a);
    return a >= 16'hFE00 && a <= 16'hFE9F;
  endfunction
  function automatic bit granted(logic [15:0] a, logic [1:0] m, logic b);
    return in_win(a) && !b && m < 2;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d, logic [1:0] m, logic b);
    bus_addr = a; wr_data = d; lcd_mode = m; copy_busy = b; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
    if (granted(a, m, b)) begin model[a-16'hFE00] = d; known[a-16'hFE00] = 1; end
  endtask

  task automatic cpu_rd(string req, logic [15:0] a, logic [1:0] m, logic b);
    logic [7:0] e;
    bus_addr = a; lcd_mode = m; copy_busy = b; bus_rd = 1;
    @(posedge clk); #1 bus_rd = 0;
    if (!granted(a, m, b)) e = 8'hFF;
    else if (known[a-16'hFE00]) e = model[a-16'hFE00];
    else return;
    check(req, rd_data, e);
  endtask

  task automatic cp_wr(logic [7:0] i, logic [7:0] d, logic [1:0] m, logic b);
    cp_idx = i; cp_data = d; lcd_mode = m; copy_busy = b; cp_we = 1;
    @(posedge clk); #1 cp_we = 0; copy_busy = 0;
    if (b) begin model[i] = d; known[i] = 1; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    check("R1 reset", rd_data, 8'hFF);
    cpu_wr(16'hFE00, 8'h11, 0, 0);
    cpu_rd("R2 R4 R5 low edge", 16'hFE00, 1, 0);
    cpu_wr(16'hFE9F, 8'h22, 1, 0);
    cpu_rd("R2 R5 high edge", 16'hFE9F, 0, 0);
    cpu_wr(16'hFE10, 8'h33, 0, 0);
    cpu_wr(16'hFE10, 8'h44, 3, 0);
    cpu_rd("R6 drawing write dropped", 16'hFE10, 0, 0);
    cpu_wr(16'hFE10, 8'h55, 2, 0);
    cpu_rd("R6 scan write dropped", 16'hFE10, 1, 0);
    cpu_rd("R6 R3 read in drawing", 16'hFE10, 3, 0);
    cpu_rd("R7 read while busy", 16'hFE10, 0, 1);
    cpu_wr(16'hFE10, 8'h66, 0, 1);
    cpu_rd("R7 busy write dropped", 16'hFE10, 0, 0);
    cpu_rd("R9 prohibited", 16'hFEA0, 0, 0);
    cpu_rd("R9 below window", 16'hFDFF, 0, 0);
    cp_wr(8'h10, 8'h77, 3, 1);
    cpu_rd("R8 copy write lands", 16'hFE10, 0, 0);
    cp_wr(8'h10, 8'h88, 0, 0);
    cpu_rd("R8 copy idle ignored", 16'hFE10, 0, 0);
    bus_addr = 16'hFE00; lcd_mode = 0; copy_busy = 1; bus_rd = 1;
    @(posedge clk); #1 copy_busy = 0;
    check("R10 same-cycle busy", rd_data, 8'hFF);
    bus_rd = 0;
    @(posedge clk); #1;
    check("R11 hold", rd_data, 8'hFF);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [1:0] m;
      logic b;
      a = 16'hFDF0 + 16'($urandom_range(0, 200));
      m = 2'($urandom);
      b = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 2))
        0: cpu_wr(a, 8'($urandom), m, b);
        1: cpu_rd("R4 R5 R6 R7 R9 random", a, m, b);
        default: cp_wr(8'($urandom_range(0, 159)), 8'($urandom), m, b);
      endcase
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule